// File: doc/BRIEF.md
# Arbitrating Half-Duplex Bus Transmitter

This block puts one pending frame onto a shared two-wire differential line, the kind used by multi-drop serial buses. It watches the receive line to decide when the bus has gone quiet. It waits out a per-node permit delay before it starts. It sends each byte with a start bit and a stop bit, and it reads every bit back off the line while it sends. In arbitration mode, the first byte goes out at a slow rate. Only its zero bits are actively driven, so two nodes that start together sort themselves out bit by bit. The node that reads back a zero where it sent a one withdraws and tries again after the next quiet period. Once the first byte is through, the rest of the frame goes out at the fast rate.

Three other modes share the same datapath. Plain half-duplex and full-duplex modes send the whole frame fully driven. Break-sync mode starts at the permit point if a frame was already waiting. If the frame arrived later, the block waits for a longer maximum-idle time and then sends a break character to wake the bus. The frame source shows byte `rd_idx` on `rd_byte` and holds `tx_req` high until `tx_done`. Dropping `tx_req` while no frame is on the line cancels any further retries.

Top module: `arb_bus_tx`

## Requirements
- R1: After reset and whenever no frame is being sent, `tx` is 1 and `tx_en` is 0. `bus_idle` goes to 1 once `rx` has stayed high for `idle_wait` bit times at the slow rate (`div_ls`+1 clocks per bit).
- R2: Mode encoding is 0 plain half-duplex, 1 arbitration, 2 break-sync and 3 full-duplex. In modes 0, 1 and 3, a frame with `tx_req` high and `tx_len` not zero starts as soon as the idle bit count reaches `permit`.
- R3: Each byte is sent as a 0 start bit, 8 data bits least significant first, and a 1 stop bit. Bytes `rd_idx` = 0 to `tx_len`-1 follow each other with no gap. `tx_done` pulses for one clock after the last stop bit.
- R4: Byte 0 uses `div_ls`+1 clocks per bit. Every later byte of the frame uses `div_hs`+1 clocks per bit.
- R5: In mode 1, during byte 0, `tx_en` is 1 only while a 0 bit is sent. `tx` carries the bit value, or stays at 0 throughout when `hold_low` is set.
- R6: When the block sends a 1 and reads back a 0, `collision` pulses and the block releases the line at once. It starts the frame again from byte 0 once the idle count reaches the permit again, for as long as `tx_req` stays high.
- R7: When the block sends a 0 and reads back a 1, `tx_err` pulses and the frame carries on to the end.
- R8: Read-back takes place at clock ⌊3·(div+1)/4⌋ within each bit, counting from 0 at the start of the bit.
- R9: In mode 2, a frame that is pending while the idle count equals `permit` starts there. Otherwise the block waits until the idle count reaches `max_idle`. It then sends a break of 10 slow-rate bit times at 0 and one slow-rate bit at 1, and then the frame.
- R10: In modes 0, 2 and 3 (but not after a break), `tx_en` rises `pre_len` slow-rate bit times before the start bit. Mode 1 ignores `pre_len`.
- R11: In mode 3, `rx` is not checked while sending, so `collision` and `tx_err` never pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Operating mode (see R2) |
| hold_low | input | 1 | Keep tx at 0 during the arbitration byte |
| idle_wait | input | 8 | Bit times of quiet line before bus_idle |
| permit | input | IDLE_W | Idle bit count at which sending may start |
| max_idle | input | IDLE_W | Idle bit count that triggers a break in mode 2 |
| pre_len | input | 2 | Bit times tx_en leads the start bit |
| div_ls | input | DIV_W | Slow-rate divider (clocks per bit minus one) |
| div_hs | input | DIV_W | Fast-rate divider (clocks per bit minus one) |
| tx_req | input | 1 | Frame pending |
| tx_len | input | LEN_W | Frame length in bytes |
| rd_byte | input | 8 | Frame byte at rd_idx |
| rx | input | 1 | Sampled receive line |
| rd_idx | output | LEN_W | Index of the byte being sent |
| tx | output | 1 | Transmit data |
| tx_en | output | 1 | Driver enable |
| bus_idle | output | 1 | Line has been quiet for idle_wait bit times |
| tx_done | output | 1 | Frame completed (one-clock pulse) |
| collision | output | 1 | Arbitration lost (one-clock pulse) |
| tx_err | output | 1 | Sent 0 but read back 1 (one-clock pulse) |

## Verification
The bench models a second node on a wired-AND line. That node takes the first data bit from the block. A block that missed the loss would drive over the winner. A block that did not retry would never deliver its frame. A block that kept retrying would keep the driver busy after `tx_req` drops.

A delay of five clocks on the read-back path, with eight-clock bits, tells a three-quarter sampling point from a half-bit one, which would flag false errors. A delay of seven clocks must still be flagged.

Break-sync with a request that arrives late must produce a break of exactly ten slow bit times at the maximum-idle point, not a start at the permit point. The driver lead time is measured in clocks so that it can be told apart in mode 1, which ignores it, and in mode 0, which applies it.

// File: rtl/arb_bus_tx.sv
module arb_bus_tx #(
  parameter int DIV_W  = 16,
  parameter int IDLE_W = 10,
  parameter int LEN_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              hold_low,
  input  logic [7:0]        idle_wait,
  input  logic [IDLE_W-1:0] permit,
  input  logic [IDLE_W-1:0] max_idle,
  input  logic [1:0]        pre_len,
  input  logic [DIV_W-1:0]  div_ls,
  input  logic [DIV_W-1:0]  div_hs,
  input  logic              tx_req,
  input  logic [LEN_W-1:0]  tx_len,
  input  logic [7:0]        rd_byte,
  input  logic              rx,
  output logic [LEN_W-1:0]  rd_idx,
  output logic              tx,
  output logic              tx_en,
  output logic              bus_idle,
  output logic              tx_done,
  output logic              collision,
  output logic              tx_err
);
  localparam logic [1:0] M_ARB = 2'd1;
  localparam logic [1:0] M_BS  = 2'd2;
  localparam logic [1:0] M_FD  = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_BRK, S_DATA} st_t;

  st_t               st;
  logic [DIV_W-1:0]  bc;
  logic [3:0]        bitn;
  logic [LEN_W-1:0]  idx;
  logic              fast;
  logic [IDLE_W-1:0] idle;
  logic              cur_bit;

  wire [DIV_W-1:0] div = fast ? div_hs : div_ls;
  wire [DIV_W+1:0] d1 = {2'b00, div} + {{(DIV_W+1){1'b0}}, 1'b1};
  wire [DIV_W+1:0] samp = (d1 + {d1[DIV_W:0], 1'b0}) >> 2;
  wire bit_end = (bc == div);
  wire in_idle = (st == S_IDLE);
  wire in_data = (st == S_DATA);
  wire arb_ph  = (mode == M_ARB) && !fast;

  wire chk_on   = in_data && (mode != M_FD) && ({2'b00, bc} == samp);
  wire coll_hit = chk_on && cur_bit && !rx;
  wire err_hit  = chk_on && !cur_bit && rx;

  wire has_frame = tx_req && (tx_len != '0);
  wire go_perm   = has_frame && (mode != M_BS) && (idle >= permit);
  wire bs_now    = has_frame && (mode == M_BS) && (idle == permit);
  wire bs_late   = has_frame && (mode == M_BS) && (idle >= max_idle);
  wire skip_pre  = (mode == M_ARB) || (pre_len == 2'd0);

  assign rd_idx   = idx;
  assign bus_idle = in_idle && (idle >= {{(IDLE_W-8){1'b0}}, idle_wait});

  always_comb begin
    case (bitn)
      4'd0:    cur_bit = 1'b0;
      4'd9:    cur_bit = 1'b1;
      default: cur_bit = rd_byte[3'(bitn - 4'd1)];
    endcase
  end

  always_comb begin
    tx    = 1'b1;
    tx_en = 1'b0;
    case (st)
      S_PRE:  tx_en = 1'b1;
      S_BRK: begin
        tx_en = 1'b1;
        tx    = (bitn == 4'd10);
      end
      S_DATA: begin
        tx_en = arb_ph ? !cur_bit : 1'b1;
        tx    = (arb_ph && hold_low) ? 1'b0 : cur_bit;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      bc        <= '0;
      bitn      <= '0;
      idx       <= '0;
      fast      <= 1'b0;
      idle      <= '0;
      tx_done   <= 1'b0;
      collision <= 1'b0;
      tx_err    <= 1'b0;
    end else begin
      tx_done   <= 1'b0;
      collision <= 1'b0;
      tx_err    <= 1'b0;
      case (st)
        S_IDLE: begin
          if (bs_late || go_perm || bs_now) begin
            st   <= bs_late ? S_BRK : (skip_pre ? S_DATA : S_PRE);
            bc   <= '0;
            bitn <= '0;
            idx  <= '0;
            fast <= 1'b0;
            idle <= '0;
          end else if (!rx) begin
            bc   <= '0;
            idle <= '0;
          end else if (bit_end) begin
            bc <= '0;
            if (idle != '1) idle <= idle + IDLE_W'(1);
          end else begin
            bc <= bc + DIV_W'(1);
          end
        end
        S_PRE: begin
          if (bit_end) begin
            bc <= '0;
            if (bitn + 4'd1 == {2'b00, pre_len}) begin
              st   <= S_DATA;
              bitn <= '0;
            end else begin
              bitn <= bitn + 4'd1;
            end
          end else begin
            bc <= bc + DIV_W'(1);
          end
        end
        S_BRK: begin
          if (bit_end) begin
            bc <= '0;
            if (bitn == 4'd10) begin
              st   <= S_DATA;
              bitn <= '0;
            end else begin
              bitn <= bitn + 4'd1;
            end
          end else begin
            bc <= bc + DIV_W'(1);
          end
        end
        S_DATA: begin
          if (coll_hit) begin
            st        <= S_IDLE;
            collision <= 1'b1;
            bc        <= '0;
            bitn      <= '0;
            idx       <= '0;
            fast      <= 1'b0;
            idle      <= '0;
          end else begin
            if (err_hit) tx_err <= 1'b1;
            if (bit_end) begin
              bc <= '0;
              if (bitn == 4'd9) begin
                bitn <= '0;
                if (idx + LEN_W'(1) == tx_len) begin
                  st      <= S_IDLE;
                  tx_done <= 1'b1;
                  idx     <= '0;
                  fast    <= 1'b0;
                  idle    <= '0;
                end else begin
                  idx  <= idx + LEN_W'(1);
                  fast <= 1'b1;
                end
              end else begin
                bitn <= bitn + 4'd1;
              end
            end else begin
              bc <= bc + DIV_W'(1);
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module arb_bus_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       hold_low,
  input logic       in_idle,
  input logic       in_data,
  input logic       fast,
  input logic       tx,
  input logic       tx_en,
  input logic       tx_done,
  input logic       collision,
  input logic       tx_err
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> (tx && !tx_en)); // R1
  AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_done && collision)); // R3
  AST_FAST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fast |=> (fast || in_idle)); // R4
  AST_ARB_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && mode == 2'd1 && !fast && !hold_low && tx_en) |-> !tx); // R5
  AST_ARB_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && mode == 2'd1 && !fast && hold_low) |-> !tx); // R5
  AST_COLL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    collision |-> (!tx_en && in_idle)); // R6
  AST_FD_NO_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && $past(mode) == 2'd3) |-> (!collision && !tx_err)); // R11
endmodule

bind arb_bus_tx arb_bus_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .hold_low(hold_low),
  .in_idle(in_idle), .in_data(in_data), .fast(fast), .tx(tx),
  .tx_en(tx_en), .tx_done(tx_done), .collision(collision), .tx_err(tx_err)
);

// File: tb/arb_bus_tx_bench.sv
`timescale 1ns/1ps
module arb_bus_tx_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd1;
  logic        hold_low = 1'b0;
  logic [7:0]  idle_wait = 8'd4;
  logic [9:0]  permit = 10'd12;
  logic [9:0]  max_idle = 10'd40;
  logic [1:0]  pre_len = 2'd0;
  logic [15:0] div_ls = 16'd7;
  logic [15:0] div_hs = 16'd7;
  logic        tx_req = 1'b0;
  logic [8:0]  tx_len = 9'd1;
  logic [7:0]  rd_byte;
  logic        rx;
  logic [8:0]  rd_idx;
  logic        tx, tx_en, bus_idle, tx_done, collision, tx_err;

  logic [7:0]  fr [16];
  logic        ext_low = 1'b0, force_hi = 1'b0, force_lo = 1'b0;
  int          dly = 0;
  logic        line;
  logic [15:0] hist = '1;
  int          n_done = 0, n_coll = 0, n_err = 0;
  int          checks = 0, fails = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  assign rd_byte = fr[rd_idx[3:0]];
  always_comb line = force_lo ? 1'b0 : force_hi ? 1'b1 : !(ext_low || (tx_en && !tx));
  always @(posedge clk) hist <= {hist[14:0], line};
  assign rx = (dly == 0) ? line : hist[dly-1];

  always @(posedge clk) begin
    if (tx_done)   n_done <= n_done + 1;
    if (collision) n_coll <= n_coll + 1;
    if (tx_err)    n_err  <= n_err + 1;
  end

  arb_bus_tx u_arb_bus_tx (
    .clk(clk), .rst_n(rst_n), .mode(mode), .hold_low(hold_low),
    .idle_wait(idle_wait), .permit(permit), .max_idle(max_idle),
    .pre_len(pre_len), .div_ls(div_ls), .div_hs(div_hs), .tx_req(tx_req),
    .tx_len(tx_len), .rd_byte(rd_byte), .rx(rx), .rd_idx(rd_idx), .tx(tx),
    .tx_en(tx_en), .bus_idle(bus_idle), .tx_done(tx_done),
    .collision(collision), .tx_err(tx_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reset_dut();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int bit_clks(input int dv);
    return dv + 1;
  endfunction

  task automatic wait_low(output int t);
    t = 0;
    while (line !== 1'b0 && t < 20000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic expect_frame(input int len, input int dls, input int dhs);
    for (int b = 0; b < len; b++) begin
      int d;
      int t;
      logic [7:0] v;
      d = bit_clks(b == 0 ? dls : dhs);
      wait_low(t);
      wait_cyc(d / 2);
      chk(line == 1'b0, "R3 start bit", line, 0);
      for (int k = 0; k < 8; k++) begin
        wait_cyc(d);
        v[k] = line;
      end
      wait_cyc(d);
      chk(line == 1'b1, "R3 stop bit", line, 1);
      chk(v == fr[b], "R4 byte value at rate", v, fr[b]);
    end
  endtask

  task automatic wait_done(input int prev);
    int t = 0;
    while (n_done == prev && t < 20000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic other_node(input logic [7:0] val, input int d);
    logic [9:0] f;
    f = {1'b1, val, 1'b0};
    for (int i = 0; i < 10; i++) begin
      ext_low = !f[i];
      wait_cyc(d);
    end
    ext_low = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int t, n, c0, e0, d0, r;
    r = $urandom(32'd4242);

    // R1: reset state and idle detection
    mode = 2'd1; div_ls = 16'd7; div_hs = 16'd7; permit = 10'd500; tx_req = 1'b0;
    rst_n = 1'b0;
    wait_cyc(3);
    chk(tx == 1'b1 && tx_en == 1'b0, "R1 reset outputs", {tx, tx_en}, 2);
    chk(bus_idle == 1'b0, "R1 bus_idle at reset", bus_idle, 0);
    rst_n = 1'b1;
    wait_cyc(30);
    chk(bus_idle == 1'b0, "R1 bus_idle early", bus_idle, 0);
    wait_cyc(4);
    chk(bus_idle == 1'b1, "R1 bus_idle after idle_wait", bus_idle, 1);

    // R2: start at permit point
    permit = 10'd12; fr[0] = 8'hA5; tx_len = 9'd1; tx_req = 1'b1;
    reset_dut();
    t = 0;
    while (tx_en !== 1'b1 && t < 5000) begin
      @(negedge clk);
      t++;
    end
    chk(t >= 95 && t <= 99, "R2 start at permit", t, 97);
    d0 = n_done;
    wait_done(d0);
    tx_req = 1'b0;

    // R3 R4 R9 R10: random frames in modes 0..2
    for (int it = 0; it < 12; it++) begin
      int len;
      int dl;
      int dh;
      dl = 3 + int'($urandom % 9);
      dh = 2 + int'($urandom % (dl - 1));
      len = 1 + int'($urandom % 6);
      div_ls = 16'(dl); div_hs = 16'(dh);
      mode = 2'($urandom % 3);
      pre_len = 2'($urandom % 4);
      hold_low = 1'($urandom % 2);
      tx_len = 9'(len);
      for (int i = 0; i < len; i++) fr[i] = 8'($urandom);
      tx_req = 1'b1;
      d0 = n_done;
      reset_dut();
      expect_frame(len, dl, dh);
      wait_done(d0);
      chk(n_done == d0 + 1, "R3 done pulse", n_done - d0, 1);
      tx_req = 1'b0;
    end
    pre_len = 2'd0; hold_low = 1'b0;

    // R5: recessive ones in arbitration byte
    for (int h = 0; h < 2; h++) begin
      int en_cnt;
      int hi_cnt;
      mode = 2'd1; hold_low = 1'(h); div_ls = 16'd7; div_hs = 16'd3;
      fr[0] = 8'hFF; fr[1] = 8'h3C; tx_len = 9'd2; tx_req = 1'b1;
      d0 = n_done;
      reset_dut();
      while (tx_en !== 1'b1) @(negedge clk);
      en_cnt = 0; hi_cnt = 0;
      for (int i = 0; i < 80; i++) begin
        if (tx_en) en_cnt++;
        if (tx) hi_cnt++;
        @(negedge clk);
      end
      chk(en_cnt == 8, "R5 tx_en only on zero bits", en_cnt, 8);
      if (h == 1) chk(hi_cnt == 0, "R5 hold_low keeps tx low", hi_cnt, 0);
      wait_done(d0);
      tx_req = 1'b0;
    end
    hold_low = 1'b0;

    // R6: lose arbitration, back off, retry
    mode = 2'd1; div_ls = 16'd7; div_hs = 16'd3; permit = 10'd12;
    fr[0] = 8'h05; fr[1] = 8'h3C; tx_len = 9'd2; tx_req = 1'b1;
    c0 = n_coll; d0 = n_done;
    reset_dut();
    while (tx_en !== 1'b1) @(negedge clk);
    other_node(8'h04, 8);
    chk(n_coll == c0 + 1, "R6 collision flagged", n_coll - c0, 1);
    chk(n_done == d0, "R6 no done after loss", n_done - d0, 0);
    expect_frame(2, 7, 3);
    wait_done(d0);
    chk(n_done == d0 + 1, "R6 retry completes", n_done - d0, 1);
    tx_req = 1'b0;

    // R6: cancel by dropping request after loss
    tx_req = 1'b1;
    c0 = n_coll;
    reset_dut();
    while (tx_en !== 1'b1) @(negedge clk);
    other_node(8'h04, 8);
    tx_req = 1'b0;
    n = 0;
    for (int i = 0; i < 480; i++) begin
      if (tx_en) n++;
      @(negedge clk);
    end
    chk(n_coll == c0 + 1 && n == 0, "R6 cancel stops retry", n, 0);

    // R7: sent 0 read back 1
    mode = 2'd0; div_ls = 16'd4; div_hs = 16'd4;
    fr[0] = 8'h00; fr[1] = 8'h00; tx_len = 9'd2;
    force_hi = 1'b1; tx_req = 1'b1;
    c0 = n_coll; e0 = n_err; d0 = n_done;
    reset_dut();
    wait_done(d0);
    tx_req = 1'b0; force_hi = 1'b0;
    chk(n_err > e0, "R7 tx_err flagged", n_err - e0, 1);
    chk(n_coll == c0 && n_done == d0 + 1, "R7 frame continues", n_done - d0, 1);

    // R8: three-quarter readback point
    mode = 2'd0; div_ls = 16'd7; div_hs = 16'd7;
    fr[0] = 8'h55; fr[1] = 8'hAA; tx_len = 9'd2; dly = 5;
    c0 = n_coll; e0 = n_err; d0 = n_done; tx_req = 1'b1;
    reset_dut();
    wait_done(d0);
    tx_req = 1'b0;
    chk(n_err == e0 && n_coll == c0, "R8 delay 5 tolerated", (n_err - e0) + (n_coll - c0), 0);
    dly = 7;
    c0 = n_coll; e0 = n_err; tx_req = 1'b1;
    reset_dut();
    t = 0;
    while (n_err == e0 && n_coll == c0 && t < 400) begin
      @(negedge clk);
      t++;
    end
    tx_req = 1'b0;
    chk(n_err != e0 || n_coll != c0, "R8 delay 7 detected", (n_err - e0) + (n_coll - c0), 1);
    dly = 0;
    reset_dut();

    // R9: late request in break-sync mode sends a break
    mode = 2'd2; div_ls = 16'd3; div_hs = 16'd2; permit = 10'd12; max_idle = 10'd40;
    pre_len = 2'd2; fr[0] = 8'h81; fr[1] = 8'h7E; tx_len = 9'd2; tx_req = 1'b0;
    d0 = n_done;
    reset_dut();
    wait_cyc(80);
    tx_req = 1'b1;
    chk(tx_en == 1'b0, "R9 no start after permit passed", tx_en, 0);
    wait_low(t);
    chk(t + 80 >= 159 && t + 80 <= 163, "R9 break at max_idle", t + 80, 161);
    n = 0;
    while (line == 1'b0 && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk(n == 40, "R9 break length", n, 40);
    expect_frame(2, 3, 2);
    wait_done(d0);
    tx_req = 1'b0;
    pre_len = 2'd0;

    // R10: driver lead time
    for (int m = 0; m < 2; m++) begin
      mode = 2'(m); pre_len = 2'd3; div_ls = 16'd5; div_hs = 16'd5;
      permit = 10'd12; fr[0] = 8'h12; tx_len = 9'd1; tx_req = 1'b1;
      d0 = n_done;
      reset_dut();
      while (tx_en !== 1'b1) @(negedge clk);
      n = 0;
      while (line !== 1'b0 && n < 1000) begin
        @(negedge clk);
        n++;
      end
      chk(n == (m == 0 ? 18 : 0), "R10 tx_en lead", n, m == 0 ? 18 : 0);
      wait_done(d0);
      tx_req = 1'b0;
    end
    pre_len = 2'd0;

    // R11: full-duplex ignores readback
    mode = 2'd3; div_ls = 16'd4; div_hs = 16'd4;
    fr[0] = 8'hF0; fr[1] = 8'h0F; tx_len = 9'd2;
    c0 = n_coll; e0 = n_err; d0 = n_done; tx_req = 1'b1;
    reset_dut();
    while (tx_en !== 1'b1) @(negedge clk);
    force_lo = 1'b1;
    wait_done(d0);
    force_lo = 1'b0; tx_req = 1'b0;
    chk(n_coll == c0 && n_err == e0, "R11 no readback flags", (n_coll - c0) + (n_err - e0), 0);
    chk(n_done == d0 + 1, "R11 frame completes", n_done - d0, 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule